// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block gathers event flags from a random-number core and turns them into one interrupt line, across two levels of state. At the core level three sticky flags record a finished operation (done), a continuous-test fault and an entropy health-test fault. Each flag has its own enable bit. Software clears a flag by writing a clear bit in the core control register; it cannot clear a flag by writing the status register. The enabled flags are ORed into a core pending term.

At the wrapper level a two-bit status register holds a copy of that pending term and a slave-error flag. Software clears these bits by writing 1 to them. A mask register starts with every source masked. Software cannot write the mask directly. It changes the mask through an unmask command register and a mask command register. The registered interrupt output is high while any wrapper status bit is set and not masked.

The two fault events are accepted only while the entropy source is enabled, the oscillators run and no reset is active. In legacy mode the health-test fault also needs an extra enable. The logic that produces the events is outside this block.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset the core enables, core flags and wrapper status are all zero, the mask reads 3 (all masked) and `irq` is low.
- R2: The core control register (address 0) holds the enables at bit 0 (done), bit 1 (continuous fault) and bit 2 (health fault), and reads them back. Writing 1 to bit 3, 4 or 5 clears the done, continuous-fault or health-fault flag. Bits 3 to 5 always read 0.
- R3: The core status register (address 1) shows done at bit 0, continuous fault at bit 1 and health fault at bit 3. A bus write to it changes nothing.
- R4: On any write to address 0, and on any accepted core event, wrapper status bit 0 is loaded with the OR of each flag ANDed with its enable, using the values after that update.
- R5: The wrapper status register (address 2) has bit 0 (core) and bit 1 (slave error). Writing 1 to a bit clears it. A slave-error event sets bit 1, and it wins over a clear in the same cycle.
- R6: The mask register (address 3) is read-only. Writing 1s to address 4 clears those mask bits, and writing 1s to address 5 sets them. Addresses 4 and 5 read 0.
- R7: `irq` equals the OR of wrapper status ANDed with the inverted mask. It is registered and changes on the same clock edge as the status or mask update that causes it.
- R8: Continuous-fault and health-fault events are ignored unless `srcEnable` and `oscOn` are high and `hardReset` and `softReset` are both low. Done events are always accepted.
- R9: With `legacyMode` high, a health-fault event is also ignored unless `legacyHtEn` is high.
- R10: When an event and a clear bit for the same flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register word address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for busAddr |
| evtDone | input | 1 | Operation-done event pulse |
| evtCont | input | 1 | Continuous-test fault event pulse |
| evtHealth | input | 1 | Health-test fault event pulse |
| evtSlvErr | input | 1 | Slave-error event pulse |
| srcEnable | input | 1 | Entropy source enabled |
| oscOn | input | 1 | Oscillators running |
| hardReset | input | 1 | Core held in reset |
| softReset | input | 1 | Core soft reset active |
| legacyMode | input | 1 | Older core revision behaviour |
| legacyHtEn | input | 1 | Extra health-test enable for legacy mode |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a set and a clear of the same state bit in one cycle. The bench drives a clear write and an event pulse in the same cycle, for a core flag and for the slave-error bit, and reads the result back. The other hard case is wrapper bit 0, which only follows the core pending term at update points. The bench sweeps all flag and enable pairs and sets the flags before the enables, so only the control write can make the copy correct. All 64 gating combinations are swept with both fault events, and all mask and status pairs are swept against `irq`.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int ADDR_W = 3;
  localparam int FLAG_N = 3;
  localparam int WRAP_N = 2;

  // Flag indices inside the core flag vector
  localparam int F_DONE = 0;
  localparam int F_CONT = 1;
  localparam int F_HLTH = 2;

  // Position of each flag in the core status read word
  localparam int SB_DONE = 0;
  localparam int SB_CONT = 1;
  localparam int SB_HLTH = 3;

  // Clear bits sit above the enables in the control word
  localparam int CLR_LSB = FLAG_N;

  localparam logic [ADDR_W-1:0] RA_CORE_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CORE_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] RA_WRAP_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] RA_MASK      = 3'd3;
  localparam logic [ADDR_W-1:0] RA_UNMASK    = 3'd4;
  localparam logic [ADDR_W-1:0] RA_MASKSET   = 3'd5;

  typedef struct packed {
    logic              ctrlWr;
    logic [FLAG_N-1:0] enVal;
    logic [FLAG_N-1:0] clrFlags;
    logic [FLAG_N-1:0] setFlags;
    logic              coreUpd;
    logic [WRAP_N-1:0] w1cBits;
    logic              slvSet;
    logic [WRAP_N-1:0] unmaskBits;
    logic [WRAP_N-1:0] maskBits;
  } strobe_t;
endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              evtDone,
  input  logic              evtCont,
  input  logic              evtHealth,
  input  logic              evtSlvErr,
  input  logic              srcEnable,
  input  logic              oscOn,
  input  logic              hardReset,
  input  logic              softReset,
  input  logic              legacyMode,
  input  logic              legacyHtEn,
  output strobe_t           stb
);
  localparam int USED_W = CLR_LSB + FLAG_N;

  logic faultGate;
  logic healthGate;
  logic wrCtrl, wrWrap, wrUnmask, wrMaskSet;
  logic [FLAG_N-1:0] evtVec;
  logic [FLAG_N-1:0] gateVec;
  logic unusedWrBits;

  assign unusedWrBits = ^busWrData[DATA_W-1:USED_W];

  assign faultGate  = srcEnable & oscOn & ~hardReset & ~softReset;
  assign healthGate = faultGate & (~legacyMode | legacyHtEn);

  assign wrCtrl    = busWrEn && (busAddr == RA_CORE_CTRL);
  assign wrWrap    = busWrEn && (busAddr == RA_WRAP_STAT);
  assign wrUnmask  = busWrEn && (busAddr == RA_UNMASK);
  assign wrMaskSet = busWrEn && (busAddr == RA_MASKSET);

  always_comb begin
    evtVec          = '0;
    evtVec[F_DONE]  = evtDone;
    evtVec[F_CONT]  = evtCont;
    evtVec[F_HLTH]  = evtHealth;
    gateVec         = '0;
    gateVec[F_DONE] = 1'b1;
    gateVec[F_CONT] = faultGate;
    gateVec[F_HLTH] = healthGate;
  end

  always_comb begin
    stb            = '0;
    stb.ctrlWr     = wrCtrl;
    stb.enVal      = busWrData[FLAG_N-1:0];
    stb.clrFlags   = wrCtrl ? busWrData[CLR_LSB +: FLAG_N] : '0;
    stb.setFlags   = evtVec & gateVec;
    stb.coreUpd    = wrCtrl | (|(evtVec & gateVec));
    stb.w1cBits    = wrWrap ? busWrData[WRAP_N-1:0] : '0;
    stb.slvSet     = evtSlvErr;
    stb.unmaskBits = wrUnmask ? busWrData[WRAP_N-1:0] : '0;
    stb.maskBits   = wrMaskSet ? busWrData[WRAP_N-1:0] : '0;
  end

  // R8: fault events must not pass while the source is not ready
  assert_fault_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!srcEnable || !oscOn || hardReset || softReset) |->
      (stb.setFlags[F_CONT] == 1'b0 && stb.setFlags[F_HLTH] == 1'b0));

  // R9: legacy health fault needs its extra enable
  assert_legacy_health_R9: assert property (@(posedge clk) disable iff (!rstN)
    (legacyMode && !legacyHtEn) |-> !stb.setFlags[F_HLTH]);
endmodule

// File: rtl/evt_irq_dp.sv
module evt_irq_dp
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  logic [FLAG_N-1:0] enReg, enNxt;
  logic [FLAG_N-1:0] flags, flagsNxt;
  logic [WRAP_N-1:0] wrapStat, wrapNxt;
  logic [WRAP_N-1:0] maskReg, maskNxt;
  logic              pendNxt;
  logic              irqNxt;
  logic [DATA_W-1:0] coreStatWord;

  always_comb begin
    enNxt    = stb.ctrlWr ? stb.enVal : enReg;
    flagsNxt = (flags & ~stb.clrFlags) | stb.setFlags;
    pendNxt  = |(flagsNxt & enNxt);
    wrapNxt[0] = stb.coreUpd ? pendNxt : (wrapStat[0] & ~stb.w1cBits[0]);
    wrapNxt[1] = (wrapStat[1] & ~stb.w1cBits[1]) | stb.slvSet;
    maskNxt  = (maskReg & ~stb.unmaskBits) | stb.maskBits;
    irqNxt   = |(wrapNxt & ~maskNxt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= '0;
      flags    <= '0;
      wrapStat <= '0;
      maskReg  <= '1;
      irq      <= 1'b0;
    end else begin
      enReg    <= enNxt;
      flags    <= flagsNxt;
      wrapStat <= wrapNxt;
      maskReg  <= maskNxt;
      irq      <= irqNxt;
    end
  end

  always_comb begin
    coreStatWord          = '0;
    coreStatWord[SB_DONE] = flags[F_DONE];
    coreStatWord[SB_CONT] = flags[F_CONT];
    coreStatWord[SB_HLTH] = flags[F_HLTH];
  end

  always_comb begin
    case (busAddr)
      RA_CORE_CTRL: busRdData = DATA_W'(enReg);
      RA_CORE_STAT: busRdData = coreStatWord;
      RA_WRAP_STAT: busRdData = DATA_W'(wrapStat);
      RA_MASK:      busRdData = DATA_W'(maskReg);
      default:      busRdData = '0;
    endcase
  end

  // R7: registered irq tracks the registered status and mask
  assert_irq_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq == (|(wrapStat & ~maskReg)));

  // R6: unmask command clears the named mask bits
  assert_unmask_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.unmaskBits != '0) |=> ((maskReg & $past(stb.unmaskBits)) == '0));

  // R6: mask command sets the named mask bits
  assert_mask_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.maskBits != '0) |=>
      ((maskReg & $past(stb.maskBits)) == $past(stb.maskBits)));

  // R5: slave error event always leaves bit 1 set
  assert_slv_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.slvSet |=> wrapStat[1]);

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flagChk
    // R3: a flag rises only through an accepted event
    assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!flags[i] && !stb.setFlags[i]) |=> !flags[i]);
    // R10: event beats a same-cycle clear
    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
      stb.setFlags[i] |=> flags[i]);
  end
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              evtDone,
  input  logic              evtCont,
  input  logic              evtHealth,
  input  logic              evtSlvErr,
  input  logic              srcEnable,
  input  logic              oscOn,
  input  logic              hardReset,
  input  logic              softReset,
  input  logic              legacyMode,
  input  logic              legacyHtEn,
  output logic              irq
);
  strobe_t stb;

  evt_irq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .evtDone(evtDone), .evtCont(evtCont), .evtHealth(evtHealth),
    .evtSlvErr(evtSlvErr),
    .srcEnable(srcEnable), .oscOn(oscOn), .hardReset(hardReset),
    .softReset(softReset), .legacyMode(legacyMode), .legacyHtEn(legacyHtEn),
    .stb(stb)
  );

  evt_irq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .busAddr(busAddr), .busRdData(busRdData), .irq(irq)
  );
endmodule

// File: tb/evt_irq_hub_bench.sv
`timescale 1ns/1ps
module evt_irq_hub_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic evtDone, evtCont, evtHealth, evtSlvErr;
  logic srcEnable, oscOn, hardReset, softReset, legacyMode, legacyHtEn;
  logic irq;

  int errors = 0;
  int checks = 0;
  bit doneRun = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_CSTAT = 3'd1, A_WSTAT = 3'd2,
                         A_MASK = 3'd3, A_UNMASK = 3'd4, A_MASKSET = 3'd5;

  always #10 clk = ~clk;

  evt_irq_hub u_evt_irq_hub (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .evtDone(evtDone), .evtCont(evtCont), .evtHealth(evtHealth),
    .evtSlvErr(evtSlvErr), .srcEnable(srcEnable), .oscOn(oscOn),
    .hardReset(hardReset), .softReset(softReset), .legacyMode(legacyMode),
    .legacyHtEn(legacyHtEn), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic evt(logic dn, logic ct, logic hl, logic sl);
    @(negedge clk);
    evtDone = dn; evtCont = ct; evtHealth = hl; evtSlvErr = sl;
    @(negedge clk);
    evtDone = 0; evtCont = 0; evtHealth = 0; evtSlvErr = 0;
  endtask

  task automatic gatesOn();
    srcEnable = 1; oscOn = 1; hardReset = 0; softReset = 0;
    legacyMode = 0; legacyHtEn = 0;
  endtask

  function automatic logic [31:0] statWord(logic [2:0] f);
    return {28'd0, f[2], 1'b0, f[1], f[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneRun) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rstN = 0; busAddr = 0; busWrEn = 0; busWrData = 0;
    evtDone = 0; evtCont = 0; evtHealth = 0; evtSlvErr = 0;
    gatesOn();
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_CSTAT, v); chk("R1 core status", v, 0);
    rd(A_WSTAT, v); chk("R1 wrap status", v, 0);
    rd(A_MASK, v);  chk("R1 mask", v, 3);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 enables and clear bits
    wr(A_CTRL, 32'h3F);
    rd(A_CTRL, v); chk("R2 clear bits read zero", v, 7);
    evt(1, 1, 1, 0);
    rd(A_CSTAT, v); chk("R3 all flags set", v, 32'hB);
    wr(A_CSTAT, 0);
    rd(A_CSTAT, v); chk("R3 status write ignored", v, 32'hB);
    wr(A_CTRL, 32'h7 | (1 << 3));
    rd(A_CSTAT, v); chk("R2 clear done", v, 32'hA);
    wr(A_CTRL, 32'h7 | (1 << 4));
    rd(A_CSTAT, v); chk("R2 clear cont", v, 32'h8);
    wr(A_CTRL, 32'h7 | (1 << 5));
    rd(A_CSTAT, v); chk("R2 clear health", v, 32'h0);

    // R6 command registers and unmask all
    wr(A_UNMASK, 3);
    rd(A_MASK, v); chk("R6 unmask all", v, 0);
    rd(A_UNMASK, v); chk("R6 unmask reads zero", v, 0);

    // R4/R7 sweep of flags against enables
    for (int f = 0; f < 8; f++) begin
      for (int e = 0; e < 8; e++) begin
        logic exp0;
        wr(A_CTRL, 32'h38);
        wr(A_WSTAT, 3);
        evt(f[0], f[1], f[2], 0);
        wr(A_CTRL, e);
        exp0 = |(f[2:0] & e[2:0]);
        rd(A_CSTAT, v); chk("R3 status layout", v, statWord(f[2:0]));
        rd(A_WSTAT, v); chk("R4 pending copy", v, {31'd0, exp0});
        chk("R7 irq follows", {31'd0, irq}, {31'd0, exp0});
      end
    end
    // R5 W1C on core bit
    wr(A_WSTAT, 1);
    rd(A_WSTAT, v); chk("R5 w1c core bit", v, 0);
    chk("R7 irq after w1c", {31'd0, irq}, 0);

    // R6/R7 sweep of mask against status
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        wr(A_CTRL, 32'h38);
        wr(A_WSTAT, 3);
        if (s[0]) begin evt(1, 0, 0, 0); wr(A_CTRL, 1); end
        if (s[1]) evt(0, 0, 0, 1);
        wr(A_MASKSET, 3);
        wr(A_UNMASK, ~m & 3);
        rd(A_MASK, v);    chk("R6 mask value", v, m);
        rd(A_MASKSET, v); chk("R6 maskset reads zero", v, 0);
        rd(A_WSTAT, v);   chk("R5 wrap status", v, s);
        chk("R7 irq mask", {31'd0, irq}, {31'd0, |(s[1:0] & ~m[1:0])});
      end
    end

    // R8/R9 gating sweep
    for (int g = 0; g < 64; g++) begin
      logic ok, hok;
      wr(A_CTRL, 32'h38);
      @(negedge clk);
      srcEnable = g[0]; oscOn = g[1]; hardReset = g[2];
      softReset = g[3]; legacyMode = g[4]; legacyHtEn = g[5];
      evt(1, 1, 1, 0);
      gatesOn();
      ok  = g[0] & g[1] & ~g[2] & ~g[3];
      hok = ok & (~g[4] | g[5]);
      rd(A_CSTAT, v); chk("R8 R9 gated flags", v, statWord({hok, ok, 1'b1}));
    end

    // R10 same-cycle event and clear
    evt(1, 1, 1, 0);
    @(negedge clk);
    busAddr = A_CTRL; busWrData = 32'h38; busWrEn = 1; evtCont = 1;
    @(negedge clk);
    busWrEn = 0; evtCont = 0;
    rd(A_CSTAT, v); chk("R10 event beats clear", v, 32'h2);

    // R5 slave error beats W1C
    @(negedge clk);
    busAddr = A_WSTAT; busWrData = 2; busWrEn = 1; evtSlvErr = 1;
    @(negedge clk);
    busWrEn = 0; evtSlvErr = 0;
    rd(A_WSTAT, v); chk("R5 slave set wins", v & 2, 2);
    wr(A_WSTAT, 2);
    rd(A_WSTAT, v); chk("R5 slave w1c", v & 2, 0);

    doneRun = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule